// File: doc/BRIEF.md
# Burst Column Sequencer

This block turns a programmed mode word into the column addresses of a memory burst, one per clock. A controller first writes a mode word that sets the burst length, the address order, the read latency and a single-column write option. Each start pulse then launches a burst from a given 8-bit column. The block steps through the columns in the order the mode selects and holds a burst-active flag for as long as the burst runs.

For reads, the block also gives the timing on the data side. A read-data-valid strobe follows each issued read column after the programmed latency. Per-byte output enables are derived from byte mask inputs, which take effect two clocks after they are sampled. A mode word that uses a reserved code, or asks for a full-page burst in interleaved order, is refused: it raises an error flag and leaves the previous settings in force. The memory array and command arbitration are handled outside this block.

Top module: `burst_col_seq`

## Requirements
- R1: A legal mode word written with `mode_we_i` takes effect for the next burst. Bits [2:0] give the burst length: 000=1, 001=2, 010=4, 011=8, 111=full page (256 columns). Bit 3 gives the order: 0=sequential, 1=interleaved. Bits [6:4] give the read latency: 010=2, 011=3. Bit 9 is the single-write option. Bits [8:7] must be 00.
- R2: A mode word that is not legal sets `mode_err_o` to 1 on the clock that loads it, and the previous mode stays in force. Words that are not legal are: any other length or latency code, nonzero bits [8:7], and interleaved order combined with full page. A later legal word clears `mode_err_o`.
- R3: On the clock after `start_i` is sampled, `active_o` is 1 and `col_o` equals the start column. A non-full-page burst keeps `active_o` high for exactly its length in cycles.
- R4: In sequential order, the low log2(length) bits of the column count up from the start value and wrap within the burst. The upper bits stay fixed.
- R5: In interleaved order, the low bits of the column are the start column's low bits XOR the burst index (start 5, length 8 gives 5,4,7,6,1,0,3,2).
- R6: A full-page burst increments the column, wraps from 255 to 0, and runs until `stop_i` is sampled, after which `active_o` is 0 on the next cycle.
- R7: `stop_i` is ignored unless the running burst is full page.
- R8: With bit 9 set, a write burst lasts one column, while a read burst keeps the programmed length.
- R9: `rd_valid_o` is 1 exactly read-latency clocks after each cycle in which a read column is on `col_o`. Write bursts never raise it.
- R10: `oe_o[b]` is 1 only while `rd_valid_o` is 1, and is forced to 0 when `dqm_i[b]` was sampled high two clocks earlier.
- R11: After reset the block is idle with `mode_err_o`=0, `rd_valid_o`=0 and `oe_o`=0. The reset mode is length 1, sequential order, latency 2, single-write off.
- R12: A start pulse during a running burst abandons it. The new burst begins on the next cycle with its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode word write strobe |
| mode_i | input | 10 | Mode word |
| start_i | input | 1 | Burst start pulse |
| start_col_i | input | 8 | Start column of the burst |
| rd_i | input | 1 | 1 = read burst, 0 = write burst |
| stop_i | input | 1 | Burst stop request (full page only) |
| dqm_i | input | NB | Per-byte read mask |
| col_o | output | 8 | Current column address |
| active_o | output | 1 | Burst running |
| rd_valid_o | output | 1 | Read data valid, delayed by the read latency |
| oe_o | output | NB | Per-byte output enable |
| mode_err_o | output | 1 | Last mode word written was refused |

## Verification
The assertions check every cycle for three things. The first column after a start must equal the requested column. The read-valid strobe must trail the read issue cycles by exactly the current latency. No byte enable may be on when its mask was high two clocks before. A stop during a full-page burst must also end the burst on the next cycle. Column orders, burst lengths, the full-page wrap, refused mode words, stop being ignored outside full page, the single-write option and restarts need whole scenarios. The bench shows these by comparing complete column sequences against values worked out by hand.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int COL_W  = 8;
  localparam int MODE_W = 10;

  typedef struct packed {
    logic [COL_W-1:0] mask;   // burst length minus one
    logic             full;
    logic             ilv;
    logic             cl3;
    logic             wsingle;
  } mode_cfg_t;

  localparam mode_cfg_t CFG_RESET = '{mask: '0, full: 1'b0, ilv: 1'b0, cl3: 1'b0, wsingle: 1'b0};

  function automatic logic mode_legal(input logic [MODE_W-1:0] w);
    logic bl_ok, cl_ok;
    bl_ok = (w[2:0] inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111});
    cl_ok = (w[6:4] inside {3'b010, 3'b011});
    return bl_ok && cl_ok && (w[8:7] == 2'b00) && !(w[3] && (w[2:0] == 3'b111));
  endfunction

  function automatic mode_cfg_t mode_decode(input logic [MODE_W-1:0] w);
    mode_cfg_t c;
    c.full    = (w[2:0] == 3'b111);
    c.ilv     = w[3];
    c.cl3     = (w[6:4] == 3'b011);
    c.wsingle = w[9];
    case (w[2:0])
      3'b001:  c.mask = COL_W'(1);
      3'b010:  c.mask = COL_W'(3);
      3'b011:  c.mask = COL_W'(7);
      3'b111:  c.mask = '1;
      default: c.mask = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MODE_W-1:0] word_i,
  output mode_cfg_t         cfg_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= CFG_RESET;
      err_o <= 1'b0;
    end else if (we_i) begin
      if (mode_legal(word_i)) begin
        cfg_o <= mode_decode(word_i);
        err_o <= 1'b0;
      end else begin
        err_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
  import bcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  input  logic             wsingle_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             rd_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             active_o,
  output logic             rd_o,
  output logic             full_o
);
  logic [COL_W-1:0] base_q, idx_q, mask_q;
  logic             ilv_q;
  logic             one_wr;

  assign one_wr = !rd_i && wsingle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      mask_q   <= '0;
      ilv_q    <= 1'b0;
      rd_o     <= 1'b0;
      full_o   <= 1'b0;
    end else if (start_i) begin
      active_o <= 1'b1;
      base_q   <= start_col_i;
      idx_q    <= '0;
      mask_q   <= one_wr ? '0 : mask_i;
      full_o   <= full_i && !one_wr;
      ilv_q    <= ilv_i;
      rd_o     <= rd_i;
    end else if (active_o) begin
      if (full_o && stop_i) active_o <= 1'b0;
      else if (!full_o && (idx_q == mask_q)) active_o <= 1'b0;
      else idx_q <= idx_q + 1'b1;   // full page wraps at 2**COL_W
    end
  end

  logic [COL_W-1:0] step;
  assign step  = ilv_q ? (base_q ^ idx_q) : (base_q + idx_q);
  assign col_o = (base_q & ~mask_q) | (step & mask_q);
endmodule

// File: rtl/bcs_rd_timing.sv
module bcs_rd_timing #(
  parameter int NB     = 8,
  parameter int MAX_CL = 3,
  parameter int DQM_LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic          cl3_i,
  input  logic [NB-1:0] dqm_i,
  output logic          rd_valid_o,
  output logic [NB-1:0] oe_o
);
  logic [MAX_CL-1:0] pipe_q;
  logic [NB-1:0]     dqm_q [DQM_LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[MAX_CL-2:0], issue_i};
  end

  for (genvar s = 0; s < DQM_LAT; s++) begin : g_dqm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dqm_q[s] <= '0;
      else if (s == 0) dqm_q[s] <= dqm_i;
      else             dqm_q[s] <= dqm_q[(s == 0) ? 0 : s-1];
    end
  end

  assign rd_valid_o = cl3_i ? pipe_q[MAX_CL-1] : pipe_q[MAX_CL-2];
  assign oe_o       = {NB{rd_valid_o}} & ~dqm_q[DQM_LAT-1];
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int NB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              rd_i,
  input  logic              stop_i,
  input  logic [NB-1:0]     dqm_i,
  output logic [COL_W-1:0]  col_o,
  output logic              active_o,
  output logic              rd_valid_o,
  output logic [NB-1:0]     oe_o,
  output logic              mode_err_o
);
  mode_cfg_t cfg;
  logic      rd_burst, full_run, issue;

  bcs_mode_reg u_mode (
    .clk_i (clk_i), .rst_ni (rst_ni), .we_i (mode_we_i), .word_i (mode_i),
    .cfg_o (cfg), .err_o (mode_err_o)
  );

  bcs_col_gen u_col (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .mask_i (cfg.mask), .full_i (cfg.full), .ilv_i (cfg.ilv), .wsingle_i (cfg.wsingle),
    .start_i (start_i), .start_col_i (start_col_i), .rd_i (rd_i), .stop_i (stop_i),
    .col_o (col_o), .active_o (active_o), .rd_o (rd_burst), .full_o (full_run)
  );

  assign issue = active_o && rd_burst;

  bcs_rd_timing #(.NB(NB)) u_rd (
    .clk_i (clk_i), .rst_ni (rst_ni), .issue_i (issue), .cl3_i (cfg.cl3),
    .dqm_i (dqm_i), .rd_valid_o (rd_valid_o), .oe_o (oe_o)
  );
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int NB = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [7:0]    start_col_i,
  input logic          stop_i,
  input logic [NB-1:0] dqm_i,
  input logic [7:0]    col_o,
  input logic          active_o,
  input logic          rd_valid_o,
  input logic [NB-1:0] oe_o,
  input logic          full_run,
  input logic          issue,
  input logic          cl3
);
  p_first_col_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (active_o && col_o == $past(start_col_i)));

  p_stop_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && full_run && stop_i && !start_i) |=> !active_o);

  p_rd_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o == (cl3 ? $past(issue, 3) : $past(issue, 2)));

  p_mask_delay_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o & $past(dqm_i, 2)) == '0);
endmodule

bind burst_col_seq burst_col_seq_chk #(.NB(NB)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_i), .start_col_i (start_col_i),
  .stop_i (stop_i), .dqm_i (dqm_i), .col_o (col_o), .active_o (active_o),
  .rd_valid_o (rd_valid_o), .oe_o (oe_o), .full_run (full_run), .issue (issue), .cl3 (cfg.cl3)
);

// File: tb/burst_col_seq_tb_top.sv
`timescale 1ns/1ps
module burst_col_seq_tb_top;
  localparam int NB = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_we_i = 1'b0;
  logic [9:0]    mode_i = '0;
  logic          start_i = 1'b0;
  logic [7:0]    start_col_i = '0;
  logic          rd_i = 1'b0;
  logic          stop_i = 1'b0;
  logic [NB-1:0] dqm_i = '0;
  logic [7:0]    col_o;
  logic          active_o, rd_valid_o, mode_err_o;
  logic [NB-1:0] oe_o;

  always #2 clk_i = ~clk_i;

  burst_col_seq #(.NB(NB)) dut_i (.*);

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] got [300];
  int got_len;

  // {mode, start, rd, length, first eight columns}
  localparam logic [86:0] VEC [8] = '{
    {10'h023, 8'h35, 1'b1, 4'd8, 64'h3536373031323334},  // R4 seq 8
    {10'h02B, 8'h35, 1'b1, 4'd8, 64'h3534373631303332},  // R5 ilv 8
    {10'h032, 8'hA6, 1'b1, 4'd4, 64'hA6A7A4A500000000},  // R4 seq 4
    {10'h03A, 8'hA7, 1'b1, 4'd4, 64'hA7A6A5A400000000},  // R5 ilv 4
    {10'h021, 8'hFF, 1'b1, 4'd2, 64'hFFFE000000000000},  // R1 length 2
    {10'h020, 8'h12, 1'b0, 4'd1, 64'h1200000000000000},  // R1 length 1
    {10'h223, 8'h35, 1'b0, 4'd1, 64'h3500000000000000},  // R8 single write
    {10'h223, 8'h35, 1'b1, 4'd8, 64'h3536373031323334}   // R8 read still bursts
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_mode(input logic [9:0] m);
    @(negedge clk_i); mode_i = m; mode_we_i = 1'b1;
    @(negedge clk_i); mode_we_i = 1'b0;
  endtask

  task automatic run_burst(input logic [7:0] sc, input logic r);
    @(negedge clk_i); start_i = 1'b1; start_col_i = sc; rd_i = r;
    @(negedge clk_i); start_i = 1'b0;
    got_len = 0;
    while (active_o && got_len < 300) begin
      got[got_len] = col_o; got_len++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++; n_tests++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] cols;
    logic [15:0] vmask;
    bit          ok;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    check(!active_o && !mode_err_o && !rd_valid_o && oe_o == '0, "R11 reset outputs",
          {active_o, mode_err_o, rd_valid_o, oe_o}, 0);
    run_burst(8'h5A, 1'b1);
    check(got_len == 1 && got[0] == 8'h5A, "R11 reset mode length 1", got_len, 1);

    for (int v = 0; v < 8; v++) begin
      load_mode(VEC[v][86:77]);
      run_burst(VEC[v][76:69], VEC[v][68]);
      check(got_len == int'(VEC[v][67:64]), "R3 burst length", got_len, VEC[v][67:64]);
      cols = '0;
      for (int k = 0; k < 8; k++) if (k < got_len) cols[63-8*k -: 8] = got[k];
      check(cols == VEC[v][63:0], "R4/R5 column order", cols, VEC[v][63:0]);
    end

    // R2 refused words keep the length-8 mode
    load_mode(10'h023);
    load_mode(10'h024);
    check(mode_err_o, "R2 reserved length code", mode_err_o, 1);
    load_mode(10'h02F);
    check(mode_err_o, "R2 interleave with full page", mode_err_o, 1);
    load_mode(10'h04B);
    run_burst(8'h00, 1'b1);
    check(mode_err_o && got_len == 8, "R2 previous mode kept", got_len, 8);
    load_mode(10'h022);
    run_burst(8'h00, 1'b1);
    check(!mode_err_o && got_len == 4, "R2 legal word clears error", {mode_err_o, 8'(got_len)}, 4);

    // R6 full page wrap and stop
    load_mode(10'h027);
    @(negedge clk_i); start_i = 1'b1; start_col_i = 8'hFE; rd_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    ok = 1'b1;
    for (int n = 0; n < 270; n++) begin
      if (!active_o || col_o != 8'(8'hFE + n)) ok = 1'b0;
      if (n == 269) stop_i = 1'b1;
      @(negedge clk_i);
    end
    stop_i = 1'b0;
    check(ok, "R6 full page runs and wraps", ok, 1);
    check(!active_o, "R6 stop ends full page", active_o, 0);

    // R7 stop ignored at length 8
    load_mode(10'h023);
    @(negedge clk_i); start_i = 1'b1; start_col_i = 8'h40; rd_i = 1'b0;
    @(negedge clk_i); start_i = 1'b0;
    got_len = 0;
    while (active_o && got_len < 20) begin
      stop_i = (got_len == 2);
      got_len++;
      @(negedge clk_i);
    end
    stop_i = 1'b0;
    check(got_len == 8, "R7 stop ignored", got_len, 8);

    // R12 restart mid burst
    @(negedge clk_i); start_i = 1'b1; start_col_i = 8'h10; rd_i = 1'b0;
    @(negedge clk_i); start_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i); start_i = 1'b1; start_col_i = 8'h40;
    @(negedge clk_i); start_i = 1'b0;
    check(col_o == 8'h40 && active_o, "R12 restart column", col_o, 8'h40);
    got_len = 0;
    while (active_o && got_len < 20) begin got_len++; @(negedge clk_i); end
    check(got_len == 8, "R12 restart full length", got_len, 8);

    // R9 read latency 2 and 3, none for writes
    for (int c = 0; c < 3; c++) begin
      load_mode(c == 1 ? 10'h032 : 10'h022);
      @(negedge clk_i); start_i = 1'b1; start_col_i = 8'h00; rd_i = (c != 2);
      @(negedge clk_i); start_i = 1'b0;
      vmask = '0;
      for (int n = 1; n <= 12; n++) begin
        vmask[n] = rd_valid_o;
        @(negedge clk_i);
      end
      check(vmask == (c == 0 ? 16'h0078 : (c == 1 ? 16'h00F0 : 16'h0000)),
            "R9 read valid timing", vmask, c == 0 ? 16'h0078 : (c == 1 ? 16'h00F0 : 16'h0000));
    end

    // R10 byte mask two clocks later, latency 2 read of length 4
    load_mode(10'h022);
    @(negedge clk_i); start_i = 1'b1; start_col_i = 8'h00; rd_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    for (int n = 1; n <= 8; n++) begin
      if (n == 2) check(oe_o == 8'h00, "R10 no enable before valid", oe_o, 8'h00);
      if (n == 3) check(oe_o == 8'hF0, "R10 masked bytes off", oe_o, 8'hF0);
      if (n == 4) check(oe_o == 8'hFF, "R10 mask released", oe_o, 8'hFF);
      if (n == 7) check(oe_o == 8'h00, "R10 no enable after burst", oe_o, 8'h00);
      dqm_i = (n == 1) ? 8'h0F : 8'h00;
      @(negedge clk_i);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule